// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes in characters from the half-duplex I/O line of a smart card. Each character has a start bit, eight data bits sent LSB first and one even-parity bit. The line is sampled at the middle of each elementary time unit (ETU). The ETU length is set by a parameter in clock cycles. Bits are shifted into an internal register. When a character is finished it is copied to a byte that the CPU can read, and flags report completion, parity failure and overrun.

When repetition mode is on and a character fails parity, the block asks the card to send it again. It does this by driving the line low for one ETU during the guard time. The enable for that open-drain pull-down is the `err_drive` output. Consecutive failures are counted against a limit of three or four, chosen by an input. When the limit is reached, the bad byte is still delivered, with both the completion flag and the parity flag raised. Sending characters, card activation and block-level protocol handling belong to other blocks.

Top module: `sc_char_rx`

## Requirements
- R1: A character starts on a falling edge of `io_in`. If the line is high again at the middle of the start bit, the edge is ignored and nothing is delivered.
- R2: The eight data bits are sampled at mid-ETU and assembled LSB first. The finished byte appears on `rx_data`, which changes only when a character is delivered.
- R3: A character whose eight data bits and parity bit hold an even number of ones is delivered with `rx_done`=1 and `par_err`=0, whatever the mode.
- R4: With `rep_en`=0, a character with bad parity is delivered with `rx_done`=1 and `par_err`=1, and `err_drive` stays 0.
- R5: With `rep_en`=1, a bad character is not delivered while retries remain. Instead `err_drive` is 1 for exactly one ETU, starting 10.5 ETU after the start edge. The flags do not change.
- R6: The retry limit is 3 when `rep_sel`=0 and 4 when `rep_sel`=1. A bad attempt after the limit is used up raises no `err_drive`. It is delivered with `rx_done`=1 and `par_err`=1, and the bad byte is kept in `rx_data`.
- R7: A good character after one or more retries is delivered with `par_err`=0. The retry count returns to zero on every delivery, so the next character again gets the full number of retries.
- R8: If a character is delivered while `rx_done` is still 1, `rx_data` is overwritten and `overrun` becomes 1 and stays 1.
- R9: A one-cycle `flag_clr` pulse clears `rx_done`, `par_err` and `overrun`. If a delivery happens in the same cycle, the delivery sets the flags.
- R10: After reset, `rx_data`=0 and `rx_done`, `par_err`, `overrun` and `err_drive` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_in | input | 1 | Card I/O line as seen at the pad, synchronised inside |
| rep_en | input | 1 | Repetition mode enable |
| rep_sel | input | 1 | Retry limit select (0: 3, 1: 4) |
| flag_clr | input | 1 | Pulse that clears the status flags |
| rx_data | output | 8 | Last delivered character |
| rx_done | output | 1 | Character delivered |
| par_err | output | 1 | Delivered character failed parity |
| overrun | output | 1 | Delivery happened while `rx_done` was still set (sticky) |
| err_drive | output | 1 | Pull the I/O line low to request a repeat |

## Verification
The hardest state to reach from the ports is the last permitted retry failing. Getting there takes three or four back-to-back bad characters with the card's timing kept, and the retry count must not reset in between. The bench models the line as a wired-AND of the card driver and `err_drive`, so the block sees its own error signal, as it would on a real line. It then replays the same bad byte the exact number of times for each limit setting. It also checks that a good character after retries starts the count afresh.

// File: rtl/sc_char_rx.sv
module sc_char_rx #(
  parameter int ETU_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_in,
  input  logic       rep_en,
  input  logic       rep_sel,
  input  logic       flag_clr,
  output logic [7:0] rx_data,
  output logic       rx_done,
  output logic       par_err,
  output logic       overrun,
  output logic       err_drive
);
  localparam int HALF  = ETU_CYC / 2;
  localparam int POS_W = $clog2(13 * ETU_CYC + 1);
  localparam logic [POS_W-1:0] ERR_ON   = POS_W'(10 * ETU_CYC + HALF);
  localparam logic [POS_W-1:0] ERR_OFF  = POS_W'(11 * ETU_CYC + HALF);
  localparam logic [POS_W-1:0] HOLD_END = POS_W'(12 * ETU_CYC + HALF);

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_ERR} st_t;

  st_t             st;
  logic            io_m, io_s, io_q;
  logic [POS_W-1:0] pos, nxt;
  logic [3:0]      bidx;
  logic [7:0]      sh;
  logic [2:0]      rcnt;

  wire       fall    = (st == S_IDLE) && io_q && !io_s;
  wire       samp    = (st == S_RECV) && (pos == nxt);
  wire       par_bad = ^{sh, io_s};
  wire [2:0] lim     = rep_sel ? 3'd4 : 3'd3;
  wire       last    = samp && (bidx == 4'd9);
  wire       retry   = last && par_bad && rep_en && (rcnt < lim);
  wire       deliver = last && !retry;

  assign err_drive = (st == S_ERR) && (pos >= ERR_ON) && (pos < ERR_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_m <= 1'b1;
      io_s <= 1'b1;
      io_q <= 1'b1;
    end else begin
      io_m <= io_in;
      io_s <= io_m;
      io_q <= io_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pos  <= '0;
      nxt  <= '0;
      bidx <= '0;
      sh   <= '0;
      rcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (fall) begin
          st   <= S_RECV;
          pos  <= POS_W'(1);
          nxt  <= POS_W'(HALF);
          bidx <= '0;
        end
        S_RECV: begin
          pos <= pos + 1'b1;
          if (samp) begin
            nxt  <= nxt + POS_W'(ETU_CYC);
            bidx <= bidx + 1'b1;
            if (bidx == 4'd0) begin
              if (io_s) st <= S_IDLE;
            end else if (bidx != 4'd9) begin
              sh <= {io_s, sh[7:1]};
            end else if (retry) begin
              st   <= S_ERR;
              rcnt <= rcnt + 1'b1;
            end else begin
              st   <= S_IDLE;
              rcnt <= '0;
            end
          end
        end
        S_ERR: begin
          pos <= pos + 1'b1;
          if (pos == HOLD_END) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_done <= 1'b0;
      par_err <= 1'b0;
      overrun <= 1'b0;
    end else if (deliver) begin
      rx_data <= sh;
      rx_done <= 1'b1;
      par_err <= par_bad;
      overrun <= flag_clr ? 1'b0 : (overrun | rx_done);
    end else if (flag_clr) begin
      rx_done <= 1'b0;
      par_err <= 1'b0;
      overrun <= 1'b0;
    end
  end
endmodule

module sc_char_rx_chk #(
  parameter int ETU_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_data,
  input logic       rx_done,
  input logic       par_err,
  input logic       overrun,
  input logic       err_drive
);
  logic [15:0] elen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         elen <= '0;
    else if (err_drive) elen <= elen + 1'b1;
    else                elen <= '0;
  end

  a_r5_err_one_etu: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_drive) |-> (elen == 16'(ETU_CYC)));
  a_r2_data_on_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_done);
  a_r6_perr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> rx_done);
  a_r8_overrun_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> rx_done);
  a_r5_no_flag_during_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_drive && !rx_done) |=> !$rose(rx_done));
endmodule

bind sc_char_rx sc_char_rx_chk #(.ETU_CYC(ETU_CYC)) u_chk (.*);

// File: tb/sc_char_rx_tb.sv
module sc_char_rx_tb;
  localparam int ETU = 16;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ovr;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic card = 1'b1, rep_en = 1'b0, rep_sel = 1'b0, flag_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_done, par_err, overrun, err_drive;
  wire  io_in = card & ~err_drive;

  int   n_chk = 0, n_fail = 0;
  bit   ended = 1'b0;
  exp_t q[$];
  event chk_ev;

  always #2.5 clk = ~clk;

  sc_char_rx #(.ETU_CYC(ETU)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_in(io_in), .rep_en(rep_en), .rep_sel(rep_sel),
    .flag_clr(flag_clr), .rx_data(rx_data), .rx_done(rx_done), .par_err(par_err),
    .overrun(overrun), .err_drive(err_drive));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one attempt, 13 ETU long; bad flips the even parity bit
  task automatic send(input logic [7:0] d, input bit bad, input bit exp_err,
                      input bit exp_del, input bit exp_perr, input bit exp_ovr,
                      input string tag);
    logic [9:0] bits;
    bits = {(^d) ^ bad, d, 1'b0};
    for (int k = 0; k < 10; k++) begin
      card = bits[k];
      wait_cyc(ETU);
    end
    card = 1'b1;
    chk(err_drive == 1'b0, {tag, " early err"}, err_drive, 0);
    if (exp_del) begin
      q.push_back('{data: d, perr: exp_perr, ovr: exp_ovr});
      -> chk_ev;
    end else begin
      chk(rx_done == 1'b0, {tag, " no delivery"}, rx_done, 0);
    end
    wait_cyc(ETU);
    chk(err_drive == exp_err, {tag, " err window"}, err_drive, exp_err);
    wait_cyc(ETU);
    chk(err_drive == 1'b0, {tag, " err released"}, err_drive, 0);
    wait_cyc(ETU);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    wait_cyc(1);
    flag_clr = 1'b0;
    wait_cyc(1);
    chk({rx_done, par_err, overrun} == 3'b000, "R9 flags cleared",
        {rx_done, par_err, overrun}, 0);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(chk_ev);
      e = q.pop_front();
      chk(rx_done == 1'b1, "R2 rx_done on delivery", rx_done, 1);
      chk(rx_data == e.data, "R2 rx_data", rx_data, e.data);
      chk(par_err == e.perr, "R3/R4/R6 par_err", par_err, e.perr);
      chk(overrun == e.ovr, "R8 overrun", overrun, e.ovr);
    end
  end

  initial begin : watchdog
    wait_cyc(200000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin : driver
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    // R10
    chk({rx_data, rx_done, par_err, overrun, err_drive} == '0, "R10 reset state",
        {rx_data, rx_done, par_err, overrun, err_drive}, 0);

    // R3 good char, repetition off
    send(8'hA5, 0, 0, 1, 0, 0, "R3 good");
    clear_flags();

    // R1 short glitch is not a start bit
    card = 1'b0; wait_cyc(ETU / 4); card = 1'b1;
    wait_cyc(13 * ETU);
    chk(rx_done == 1'b0, "R1 glitch ignored", rx_done, 0);
    send(8'h01, 0, 0, 1, 0, 0, "R1 after glitch");
    clear_flags();

    // R4 bad parity without repetition
    send(8'h3C, 1, 0, 1, 1, 0, "R4 bad no-rep");
    clear_flags();

    // R5/R6 limit 3
    rep_en = 1'b1; rep_sel = 1'b0;
    for (int i = 0; i < 3; i++) send(8'h5A, 1, 1, 0, 0, 0, "R5 retry sel0");
    send(8'h5A, 1, 0, 1, 1, 0, "R6 exhausted sel0");
    clear_flags();

    // R6 limit 4
    rep_sel = 1'b1;
    for (int i = 0; i < 4; i++) send(8'hC3, 1, 1, 0, 0, 0, "R5 retry sel1");
    send(8'hC3, 1, 0, 1, 1, 0, "R6 exhausted sel1");
    clear_flags();

    // R7 good after retries, then count restarts
    rep_sel = 1'b0;
    send(8'h96, 1, 1, 0, 0, 0, "R7 retry a");
    send(8'h96, 1, 1, 0, 0, 0, "R7 retry b");
    send(8'h96, 0, 0, 1, 0, 0, "R7 good after retry");
    clear_flags();
    for (int i = 0; i < 3; i++) send(8'h7E, 1, 1, 0, 0, 0, "R7 full retries again");
    send(8'h7E, 0, 0, 1, 0, 0, "R7 good last");
    clear_flags();

    // R8 overrun, then R9 clear
    send(8'h11, 0, 0, 1, 0, 0, "R8 first");
    send(8'h22, 0, 0, 1, 0, 1, "R8 second");
    clear_flags();
    chk(rx_data == 8'h22, "R9 data kept after clear", rx_data, 8'h22);

    wait_cyc(10);
    finish_up();
  end
endmodule